// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a per-core countdown timer that software controls through a small register window. A 32-bit register bus carries an address, a write strobe, write data and combinational read data. Software programs an interrupt vector, a mask bit and a mode bit in the timer entry. It then chooses a clock divide ratio and writes an initial count. The live counter steps down once per prescaler tick. When it reaches zero, the block raises a one-cycle interrupt request with the programmed vector beside it, unless the mask bit is set.

In periodic mode the counter reloads from the initial count on the tick that follows expiry. The timer then fires at a fixed interval. In one-shot mode the counter rests at zero until software writes a new initial count. The divide ratio uses a non-monotonic 4-bit code, and the code for divide-by-1 sits above the codes for the larger ratios.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (only the mask set), the initial count, current count and divide registers read zero, and the interrupt request is low.
- R2: The timer entry at offset 0x320 keeps bits 7:0 as the vector, bit 16 as the mask and bit 17 as the mode (1 periodic, 0 one-shot). A read after a write returns exactly those written bits, and all other bits read zero.
- R3: The divide register at offset 0x3E0 reads back bits 3:0. It maps code 0xB to /1, 0x0 to /2, 0x1 to /4, 0x2 to /8, 0x3 to /16, 0x8 to /32, 0x9 to /64 and 0xA to /128. Every other code divides by 2.
- R4: A write to the initial count at offset 0x380 loads the current counter and restarts the prescaler. A read of offset 0x390 returns the live count, which drops by one per tick. Writes to 0x390 have no effect.
- R5: With an initial count N and divide D, the request goes high in the cycle after the N×D-th rising edge that follows the write edge. It stays high for exactly one cycle, and the vector output carries bits 7:0 of the timer entry.
- R6: In one-shot mode, after expiry the count stays at zero and no further request is raised until the initial count is written again.
- R7: In periodic mode the counter reloads from the initial count on the tick after it reaches zero, so requests repeat every (N+1)×D cycles.
- R8: While the mask bit is set, no request is raised, and the counter keeps counting down.
- R9: Writing an initial count of zero leaves the counter at zero and raises no request.
- R10: Reads of any other offset return zero, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | output | 1 | One-cycle interrupt request at expiry |
| irq_vector | output | 8 | Vector that goes with irq_req |

## Verification
The bench measures the exact expiry cycle for every divide code, including the unused codes that fall back to /2. A decoder that mapped the codes monotonically, or that was off by one tick, would fire at the wrong cycle. It measures the periodic interval, which exposes a reload that skips the extra zero tick or one that never happens. It also confirms that the counter stays at zero after one-shot expiry and after a zero initial count. It checks that a masked timer still counts while staying silent, since a design that froze the counter on mask would show a stalled current count. Read-back of the timer entry and of unmapped offsets catches fields that are lost or aliased.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned DIVCODE_W = 4;
    localparam int unsigned SHIFT_W   = 3;
    localparam int unsigned PRESC_W   = 7;
    localparam int unsigned MASK_BIT  = 16;
    localparam int unsigned MODE_BIT  = 17;

    localparam logic [ADDR_W-1:0] OFS_ENTRY = 12'h320;
    localparam logic [ADDR_W-1:0] OFS_INIT  = 12'h380;
    localparam logic [ADDR_W-1:0] OFS_LIVE  = 12'h390;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 12'h3E0;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_t;

    // log2 of the divide ratio for a divide code; unused codes give /2
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIVCODE_W-1:0] code);
        logic [SHIFT_W-1:0] s;
        case (code)
            4'hB:    s = 3'd0;
            4'h0:    s = 3'd1;
            4'h1:    s = 3'd2;
            4'h2:    s = 3'd3;
            4'h3:    s = 3'd4;
            4'h8:    s = 3'd5;
            4'h9:    s = 3'd6;
            4'hA:    s = 3'd7;
            default: s = 3'd1;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [CNT_W-1:0]     live_count,
    output entry_t               entry,
    output logic [CNT_W-1:0]     init_count,
    output logic [DIVCODE_W-1:0] div_code,
    output logic                 load,
    output logic                 presc_clear,
    output logic [DATA_W-1:0]    reg_rdata
);
    typedef struct packed {
        entry_t               entry;
        logic [CNT_W-1:0]     init;
        logic [DIVCODE_W-1:0] div;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_entry, hit_init, hit_live, hit_div, hit_none;

    always_comb begin
        hit_entry = (reg_addr == OFS_ENTRY);
        hit_init  = (reg_addr == OFS_INIT);
        hit_live  = (reg_addr == OFS_LIVE);
        hit_div   = (reg_addr == OFS_DIV);
        hit_none  = !(hit_entry || hit_init || hit_live || hit_div);

        regs_d = regs_q;
        if (reg_wr && hit_entry) begin
            regs_d.entry.vector   = reg_wdata[VEC_W-1:0];
            regs_d.entry.mask     = reg_wdata[MASK_BIT];
            regs_d.entry.periodic = reg_wdata[MODE_BIT];
        end
        if (reg_wr && hit_init) regs_d.init = reg_wdata[CNT_W-1:0];
        if (reg_wr && hit_div)  regs_d.div  = reg_wdata[DIVCODE_W-1:0];

        load        = reg_wr && hit_init;
        presc_clear = reg_wr && (hit_init || hit_div);

        reg_rdata = '0;
        if (hit_entry) begin
            reg_rdata[VEC_W-1:0] = regs_q.entry.vector;
            reg_rdata[MASK_BIT]  = regs_q.entry.mask;
            reg_rdata[MODE_BIT]  = regs_q.entry.periodic;
        end
        if (hit_init) reg_rdata = DATA_W'(regs_q.init);
        if (hit_live) reg_rdata = DATA_W'(live_count);
        if (hit_div)  reg_rdata = DATA_W'(regs_q.div);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q            <= '0;
            regs_q.entry.mask <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign entry      = regs_q.entry;
    assign init_count = regs_q.init;
    assign div_code   = regs_q.div;

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && hit_none) |-> regs_q == $past(regs_q));

    // R2
    entry_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && hit_entry) |-> regs_q.entry.vector == $past(reg_wdata[VEC_W-1:0]));
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
    import cdt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [DIVCODE_W-1:0] div_code,
    output logic                 tick
);
    typedef struct packed {
        logic [PRESC_W-1:0] pcnt;
    } presc_t;

    presc_t             st_d, st_q;
    logic [PRESC_W-1:0] limit;

    always_comb begin
        limit = (PRESC_W'(1) << div_shift(div_code)) - PRESC_W'(1);
        tick  = (st_q.pcnt >= limit);
        st_d  = st_q;
        if (clear || tick) st_d.pcnt = '0;
        else               st_d.pcnt = st_q.pcnt + PRESC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick || clear) |-> st_q.pcnt == '0);
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_count,
    input  logic             tick,
    input  entry_t           entry,
    output logic [CNT_W-1:0] live_count,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector
);
    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load) begin
            st_d.cur = load_val;
        end else if (tick) begin
            if (st_q.cur != '0) begin
                st_d.cur = st_q.cur - CNT_W'(1);
                if (st_q.cur == CNT_W'(1)) begin
                    st_d.irq = !entry.mask;
                    st_d.vec = entry.vector;
                end
            end else if (entry.periodic) begin
                st_d.cur = init_count;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_count = st_q.cur;
    assign irq_req    = st_q.irq;
    assign irq_vector = st_q.vec;

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    // R5
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> live_count == '0);

    // R8
    irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(entry.mask));

    // R6
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.cur == '0 && !entry.periodic && !load) |-> st_q.cur == '0);

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!load && st_q.cur != '0)) |-> (st_q.cur == $past(st_q.cur) ||
                                              st_q.cur == $past(st_q.cur) - CNT_W'(1)));
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
    import cdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_req,
    output logic [7:0]        irq_vector
);
    entry_t               entry;
    logic [CNT_W-1:0]     init_count;
    logic [CNT_W-1:0]     live_count;
    logic [DIVCODE_W-1:0] div_code;
    logic                 load;
    logic                 presc_clear;
    logic                 tick;

    cdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .live_count  (live_count),
        .entry       (entry),
        .init_count  (init_count),
        .div_code    (div_code),
        .load        (load),
        .presc_clear (presc_clear),
        .reg_rdata   (reg_rdata)
    );

    cdt_prescaler u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (presc_clear),
        .div_code (div_code),
        .tick     (tick)
    );

    cdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .init_count (init_count),
        .tick       (tick),
        .entry      (entry),
        .live_count (live_count),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );
endmodule

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;

    irq_countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    always #2 clk = ~clk;

    function automatic int exp_div(input logic [3:0] c);
        case (c)
            4'hB: return 1;   4'h0: return 2;   4'h1: return 4;   4'h2: return 8;
            4'h3: return 16;  4'h8: return 32;  4'h9: return 64;  4'hA: return 128;
            default: return 2;
        endcase
    endfunction

    function automatic logic [31:0] entry_word(input logic [7:0] v, input logic m, input logic p);
        return {14'd0, p, m, 8'd0, v};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // counts rising edges after the write edge until irq_req is seen
    task automatic wait_irq(input int limit, output int k, output logic [7:0] v);
        k = -1; v = '0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_req) begin k = i; v = irq_vector; break; end
        end
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq_req) seen++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int k, seen, k2;
        logic [7:0] v;
        void'($urandom(32'h00C0FFEE));

        repeat (3) @(negedge clk);
        // R1 reset values
        rd(12'h320, d); check("R1", "entry reset", d, 32'h0001_0000);
        rd(12'h380, d); check("R1", "init reset", d, 0);
        rd(12'h390, d); check("R1", "live reset", d, 0);
        rd(12'h3E0, d); check("R1", "div reset", d, 0);
        check("R1", "irq reset", {31'd0, irq_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 entry read-back of random words
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w;
            w = $urandom();
            wr(12'h320, w);
            rd(12'h320, d);
            check("R2", "entry readback", d, w & 32'h0003_00FF);
        end
        // R3 divide register readback
        wr(12'h3E0, 32'hFFFF_FFF9);
        rd(12'h3E0, d); check("R3", "div readback", d, 32'h9);

        // R10 unmapped offsets
        wr(12'h320, entry_word(8'h5A, 1'b0, 1'b1));
        wr(12'h3E0, 32'hA);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h324, 32'h0000_0000);
        rd(12'h100, d); check("R10", "unmapped read", d, 0);
        rd(12'h3FC, d); check("R10", "unmapped read hi", d, 0);
        rd(12'h320, d); check("R10", "entry untouched", d, entry_word(8'h5A, 1'b0, 1'b1));
        rd(12'h3E0, d); check("R10", "div untouched", d, 32'hA);
        rd(12'h380, d); check("R10", "init untouched", d, 0);

        // R4 live count decrements per tick at /1
        wr(12'h3E0, 32'hB);
        wr(12'h320, entry_word(8'h21, 1'b0, 1'b0));
        wr(12'h380, 32'd100);
        rd(12'h390, d); check("R4", "live after load", d, 100);
        repeat (3) begin @(posedge clk); @(negedge clk); end
        rd(12'h390, d); check("R4", "live after 3 ticks", d, 97);

        // R5/R6 directed one-shot at /4
        wr(12'h3E0, 32'h1);
        wr(12'h320, entry_word(8'hC3, 1'b0, 1'b0));
        wr(12'h380, 32'd5);
        wait_irq(200, k, v);
        check("R5", "oneshot /4 expiry cycle", k, 20);
        check("R5", "vector", v, 8'hC3);
        @(posedge clk); @(negedge clk);
        check("R5", "pulse one cycle", {31'd0, irq_req}, 0);
        quiet(100, seen);
        check("R6", "no refire", seen, 0);
        rd(12'h390, d); check("R6", "rests at zero", d, 0);
        wr(12'h390, 32'd55);
        rd(12'h390, d); check("R4", "live write ignored", d, 0);

        // R7 periodic at /2, N=6: first at 12, then every 14
        wr(12'h3E0, 32'h0);
        wr(12'h320, entry_word(8'h77, 1'b0, 1'b1));
        wr(12'h380, 32'd6);
        wait_irq(100, k, v);
        check("R7", "periodic first", k, 12);
        wait_irq(100, k2, v);
        check("R7", "periodic interval", k2, 14);
        wait_irq(100, k2, v);
        check("R7", "periodic interval 2", k2, 14);
        check("R7", "periodic vector", v, 8'h77);

        // R8 masked: counts but silent
        wr(12'h3E0, 32'hB);
        wr(12'h320, entry_word(8'h10, 1'b1, 1'b0));
        wr(12'h380, 32'd8);
        repeat (4) begin @(posedge clk); @(negedge clk); end
        rd(12'h390, d); check("R8", "masked keeps counting", d, 4);
        quiet(20, seen);
        check("R8", "masked no irq", seen, 0);
        rd(12'h390, d); check("R8", "masked reached zero", d, 0);

        // R9 zero initial count, periodic
        wr(12'h320, entry_word(8'h10, 1'b0, 1'b1));
        wr(12'h380, 32'd0);
        quiet(40, seen);
        check("R9", "zero count no irq", seen, 0);
        rd(12'h390, d); check("R9", "zero count live", d, 0);

        // R3/R5 every code, incl. unused ones, random N and vector
        for (int c = 0; c < 16; c++) begin
            int n;
            logic [7:0] vv;
            n = 1 + ($urandom() % 8);
            vv = 8'($urandom());
            wr(12'h3E0, c);
            wr(12'h320, entry_word(vv, 1'b0, 1'b0));
            wr(12'h380, n);
            wait_irq(n * exp_div(4'(c)) + 10, k, v);
            check("R3", $sformatf("code %0h expiry", c), k, n * exp_div(4'(c)));
            check("R5", "random vector", v, vv);
        end

        // random mixed one-shot runs
        for (int i = 0; i < 12; i++) begin
            logic [3:0] c;
            int n;
            c = 4'($urandom());
            n = 1 + ($urandom() % 16);
            wr(12'h3E0, c);
            wr(12'h320, entry_word(8'(i), 1'b0, 1'b0));
            wr(12'h380, n);
            wait_irq(n * exp_div(c) + 10, k, v);
            check("R5", "random expiry", k, n * exp_div(c));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule